// File: doc/BRIEF.md
# Chained Command Packet Walker

This block drains a chain of command packets held in RAM into the graphics command input. Software places packets anywhere in the low 2 MB of word-aligned memory. Every packet opens with a header word. The top byte of the header is the number of payload words that follow it. The low address bits of the header point at the next packet's header. One flag bit in the header closes the chain. On a start pulse the walker fetches headers and payload words one at a time through a single-read memory port. It presents each payload word on a valid/ready stream and raises a one-cycle done pulse when the closing packet has been drained.

The walk is only legal for memory-to-device transfers aimed at the graphics port. A start with the to-RAM direction, or with any other port number, is rejected at once with an error pulse. An optional packet-count limit turns a chain that never closes into an error instead of a hang.

Top module: `ll_cmd_walker`

## Requirements
- R1: After reset the walker is idle: `busy`, `mem_rd`, `cmd_valid`, `done` and `err` are all low.
- R2: The first memory read after an accepted start is at `base_addr & 0x001FFFFC`.
- R3: Bits 31:24 of a header give the count of payload words. The walker emits exactly that many words, in order. Each word is fetched at the previous read address plus 4, masked with 0x001FFFFC, so a header at 0x1FFFFC is followed by payload at 0x000000.
- R4: Once a packet's payload has been sent, header bit 23 set ends the chain. With bit 23 clear, the next header is read at `header & 0x001FFFFC`.
- R5: A header whose count field is zero sends no words, and only its link is followed.
- R6: A start with `dir_to_ram` = 1, or with `port_sel` other than 2 (the graphics port), raises `err` for the one cycle after the start. No memory read and no command word follow.
- R7: When the chain ends, `done` is high for exactly one cycle, and in that cycle `busy` is already low.
- R8: While `cmd_valid` is high and `cmd_ready` is low, `cmd_data` holds its value and no memory read is issued.
- R9: With `pkt_limit` nonzero, a walk that has completed `pkt_limit` packets without seeing the end flag stops with a one-cycle `err` and returns to idle. If the end flag arrives on packet number `pkt_limit`, the walk finishes with `done` and not `err`. A value of 0 disables the limit.
- R10: A start pulse while `busy` is high is ignored, and the running walk is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a walk |
| base_addr | input | 32 | Address of the first header |
| dir_to_ram | input | 1 | Transfer direction, 1 = device to RAM (rejected) |
| port_sel | input | 3 | Target peripheral number, 2 = graphics |
| pkt_limit | input | 8 | Maximum packets per walk, 0 = unlimited |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| cmd_valid | output | 1 | Command word available |
| cmd_ready | input | 1 | Command sink accepts the word |
| cmd_data | output | 32 | Command word |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse when the chain has ended |
| err | output | 1 | One-cycle pulse on a rejected start or an exhausted limit |

## Verification
The end flag and the packet limit can both apply to the same packet. The walker must then settle, in one decision cycle, between a clean finish and an error. The bench provokes this by building a three-packet chain that closes on its third packet and running it with the limit set to exactly three. A `done` pulse with no `err` is the correct result. The same chain with a limit of two must give `err`. The bench also uses a self-linked packet under a limit, and it counts both pulses and every emitted word against a walk of its own memory image.

// File: rtl/ll_cmd_walker.sv
module ll_cmd_walker #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int LEN_W     = 8,
  parameter int CNT_W     = 8,
  parameter int PORT_W    = 3,
  parameter int GFX_PORT  = 2,
  parameter int END_BIT   = 23,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 32'h001F_FFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic              dir_to_ram,
  input  logic [PORT_W-1:0] port_sel,
  input  logic [CNT_W-1:0]  pkt_limit,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [DATA_W-1:0] cmd_data,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int LEN_LSB = DATA_W - LEN_W;

  typedef enum logic [2:0] {
    S_IDLE, S_HREQ, S_HWAIT, S_PREQ, S_PWAIT, S_PSEND, S_LINK
  } st_t;

  st_t               st_q;
  logic [ADDR_W-1:0] addr_q, next_q;
  logic [LEN_W-1:0]  remain_q;
  logic              last_q;
  logic [CNT_W-1:0]  pkts_q, limit_q;
  logic [DATA_W-1:0] data_q;

  wire              bad_req  = dir_to_ram || (port_sel != PORT_W'(GFX_PORT));
  wire [LEN_W-1:0]  hdr_len  = mem_rdata[DATA_W-1 -: LEN_W];
  wire [ADDR_W-1:0] step     = (addr_q + ADDR_W'(4)) & ADDR_MASK;
  wire [CNT_W-1:0]  pkts_nxt = pkts_q + CNT_W'(1);
  wire              lim_hit  = (limit_q != '0) && (pkts_nxt == limit_q);

  assign mem_rd    = (st_q == S_HREQ) || (st_q == S_PREQ);
  assign mem_addr  = addr_q;
  assign cmd_valid = (st_q == S_PSEND);
  assign cmd_data  = data_q;
  assign busy      = (st_q != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      addr_q   <= '0;
      next_q   <= '0;
      remain_q <= '0;
      last_q   <= 1'b0;
      pkts_q   <= '0;
      limit_q  <= '0;
      data_q   <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st_q)
        S_IDLE:
          if (start) begin
            if (bad_req) begin
              err <= 1'b1;
            end else begin
              addr_q  <= base_addr & ADDR_MASK;
              pkts_q  <= '0;
              limit_q <= pkt_limit;
              st_q    <= S_HREQ;
            end
          end
        S_HREQ: st_q <= S_HWAIT;
        S_HWAIT: begin
          remain_q <= hdr_len;
          last_q   <= mem_rdata[END_BIT];
          next_q   <= mem_rdata[ADDR_W-1:0] & ADDR_MASK;
          if (hdr_len == '0) begin
            st_q <= S_LINK;
          end else begin
            addr_q <= step;
            st_q   <= S_PREQ;
          end
        end
        S_PREQ: st_q <= S_PWAIT;
        S_PWAIT: begin
          data_q <= mem_rdata;
          st_q   <= S_PSEND;
        end
        S_PSEND:
          if (cmd_ready) begin
            if (remain_q == LEN_W'(1)) begin
              st_q <= S_LINK;
            end else begin
              remain_q <= remain_q - LEN_W'(1);
              addr_q   <= step;
              st_q     <= S_PREQ;
            end
          end
        S_LINK: begin
          pkts_q <= pkts_nxt;
          if (last_q) begin
            done <= 1'b1;
            st_q <= S_IDLE;
          end else if (lim_hit) begin
            err  <= 1'b1;
            st_q <= S_IDLE;
          end else begin
            addr_q <= next_q;
            st_q   <= S_HREQ;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ll_cmd_walker_chk.sv
module ll_cmd_walker_chk #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int PORT_W    = 3,
  parameter int GFX_PORT  = 2,
  parameter logic [ADDR_W-1:0] ADDR_MASK = 32'h001F_FFFC
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              dir_to_ram,
  input logic [PORT_W-1:0] port_sel,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [DATA_W-1:0] cmd_data,
  input logic              busy,
  input logic              done,
  input logic              err
);

  a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_rd && !cmd_valid));

  a_r3_addr_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> ((mem_addr & ~ADDR_MASK) == '0));

  a_r6_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (dir_to_ram || port_sel != PORT_W'(GFX_PORT))) |=> (err && !busy));

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !err && !cmd_valid));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

  a_r8_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_rd);

endmodule

bind ll_cmd_walker ll_cmd_walker_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_W(PORT_W),
  .GFX_PORT(GFX_PORT), .ADDR_MASK(ADDR_MASK)
) u_chk (.*);

// File: tb/test_ll_cmd_walker.sv
module test_ll_cmd_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] base_addr = '0;
  logic        dir_to_ram = 1'b0;
  logic [2:0]  port_sel = 3'd2;
  logic [7:0]  pkt_limit = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic [31:0] mem_rdata = '0;
  logic        cmd_valid;
  logic        cmd_ready = 1'b1;
  logic [31:0] cmd_data;
  logic        busy, done, err;

  always #2.5 clk = ~clk;

  ll_cmd_walker i_ll_cmd_walker (.*);

  logic [31:0] mem [256];
  always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];

  int rmode = 0;
  logic [7:0] lf = 8'h5A;
  always @(negedge clk) begin
    lf <= {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    case (rmode)
      0: cmd_ready <= 1'b1;
      1: cmd_ready <= ~cmd_ready;
      default: cmd_ready <= lf[0];
    endcase
  end

  int n_chk = 0, n_fail = 0;
  logic [31:0] got [64];
  int n_got = 0, n_done = 0, n_err = 0, n_rd = 0;
  logic [31:0] first_rd = '0;

  always @(posedge clk) if (rst_n) begin
    if (cmd_valid && cmd_ready) begin
      if (n_got < 64) got[n_got] = cmd_data;
      n_got++;
    end
    if (done) n_done++;
    if (err) n_err++;
    if (mem_rd) begin
      if (n_rd == 0) first_rd = mem_addr;
      n_rd++;
    end
  end

  logic [31:0] exp_w [64];
  int exp_n;
  bit exp_err;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic model(input logic [31:0] base, input logic [7:0] limit);
    logic [31:0] a, h;
    int pk;
    a = base & 32'h001F_FFFC;
    exp_n = 0; pk = 0; exp_err = 0;
    while (pk < 100) begin
      h = mem[a[9:2]];
      for (int i = 0; i < int'(h[31:24]); i++) begin
        a = (a + 32'd4) & 32'h001F_FFFC;
        if (exp_n < 64) exp_w[exp_n] = mem[a[9:2]];
        exp_n++;
      end
      pk++;
      if (h[23]) break;
      if (limit != 0 && pk == int'(limit)) begin exp_err = 1; break; end
      a = h & 32'h001F_FFFC;
    end
  endtask

  task automatic clear_mon();
    n_got = 0; n_done = 0; n_err = 0; n_rd = 0;
  endtask

  task automatic run(input logic [31:0] base, input logic [7:0] limit, input int rm,
                     input bit poke, input string tag);
    int t;
    model(base, limit);
    @(negedge clk);
    rmode = rm;
    clear_mon();
    base_addr = base; pkt_limit = limit; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      base_addr = 32'h0000_0080; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (n_done + n_err == 0 && t < 3000) begin @(negedge clk); t++; end
    repeat (4) @(negedge clk);
    check(first_rd == (base & 32'h001F_FFFC), {tag, " R2 first read"}, first_rd, base & 32'h001F_FFFC);
    check(n_got == exp_n, {tag, " R3 word count"}, n_got, exp_n);
    for (int i = 0; i < exp_n && i < n_got && i < 64; i++)
      check(got[i] == exp_w[i], {tag, " R3 R4 word"}, got[i], exp_w[i]);
    check(n_done == (exp_err ? 0 : 1), {tag, " R7 done pulses"}, n_done, exp_err ? 0 : 1);
    check(n_err == (exp_err ? 1 : 0), {tag, " R9 err pulses"}, n_err, exp_err ? 1 : 0);
    check(busy == 1'b0, {tag, " R7 idle after end"}, busy, 0);
  endtask

  task automatic build(input int c, input int nlast);
    logic [31:0] h [3];
    h[0] = 32'h300; h[1] = 32'h200; h[2] = 32'h100;
    for (int k = 0; k < 3; k++) begin
      int len;
      logic [31:0] nx;
      len = (c >> (2 * k)) & 3;
      nx = (k < 2) ? h[k + 1] : 32'h100;
      mem[h[k][9:2]] = {8'(len), (k == nlast) ? 1'b1 : 1'b0, 2'b11, nx[20:2], 2'b11};
      for (int i = 0; i < len; i++)
        mem[h[k][9:2] + 8'(i + 1)] = 32'hC000_0000 | (c << 8) | (k << 4) | i;
    end
  endtask

  task automatic reject(input bit d, input logic [2:0] p, input string tag);
    @(negedge clk);
    clear_mon();
    dir_to_ram = d; port_sel = p; base_addr = 32'h300; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err == 1'b1, {tag, " R6 err next cycle"}, err, 1);
    repeat (8) @(negedge clk);
    check(n_rd == 0 && n_got == 0 && busy == 0, {tag, " R6 no walk"}, n_rd + n_got, 0);
    check(n_err == 1 && n_done == 0, {tag, " R6 single err"}, n_err, 1);
    dir_to_ram = 1'b0; port_sel = 3'd2;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog timeout actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hDEAD_0000 | i;
    repeat (3) @(negedge clk);
    check(!busy && !mem_rd && !cmd_valid && !done && !err, "R1 reset idle",
          {busy, mem_rd, cmd_valid, done, err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !mem_rd && !cmd_valid, "R1 idle after reset", busy, 0);

    // R3 R4 R5 sweep: all length combos over three packets and three sink patterns
    for (int c = 0; c < 64; c++) begin
      build(c, 2);
      for (int rm = 0; rm < 3; rm++)
        run(32'hE000_0303, 8'd0, rm, 1'b0, "sweep");
    end

    // R9 end flag and limit on the same packet
    build(6'b01_01_01, 2);
    run(32'h300, 8'd3, 2, 1'b0, "R9 limit equals length");
    run(32'h300, 8'd2, 0, 1'b0, "R9 limit below length");

    // R9 circular chain
    mem[32] = {8'd2, 1'b0, 2'b00, 19'(32'h80 >> 2), 2'b00};
    mem[33] = 32'h1111_0001; mem[34] = 32'h1111_0002;
    run(32'h80, 8'd3, 1, 1'b0, "R9 circular");

    // R3 wrap past top of window
    mem[255] = {8'd2, 1'b1, 23'd0};
    mem[0] = 32'hAAAA_0000; mem[1] = 32'hAAAA_0001;
    run(32'h001F_FFFC, 8'd0, 0, 1'b0, "R3 wrap");
    check(exp_w[0] == 32'hAAAA_0000, "R3 wrap model", exp_w[0], 32'hAAAA_0000);

    // R10 start while busy
    build(6'b11_11_11, 2);
    run(32'h300, 8'd0, 2, 1'b1, "R10 start while busy");

    reject(1'b1, 3'd2, "R6 to-RAM");
    reject(1'b0, 3'd1, "R6 wrong port");
    reject(1'b0, 3'd6, "R6 other port");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule